// File: doc/BRIEF.md
# Prioritized PCI Interrupt Aggregator

This block gathers level-sensitive interrupt requests from a small set of PCI device slots and from the host controller core. It merges them into one interrupt line to the CPU. Each cycle it samples the raw request levels into a status register. It gates them with a software-written enable register, and it registers both the OR of the surviving requests and the bit position of the winning request. Software can read the status, the enable bits and the resulting pending set through a word-wide register port. It can also set or clear single enable bits without a read-modify-write.

The device requests take the lowest bit positions. The core request sits at a fixed higher position, and any positions in between are holes that always read as zero. When the line was high in the previous cycle and no enabled request remains, the block raises a one-cycle spurious flag and reports the "none" index in place of a source number.

Top module: `pci_irq_combiner`

## Requirements
- R1: After a cycle with `rst` high, the enable and status registers are zero, `cpu_irq` and `spurious` are low, and `irq_idx` holds the none code (all ones, 7 by default).
- R2: Status bit i follows `dev_irq[i]` for each device, and bit 4 follows `core_irq`. Bit 3 and every bit above 4 always read as zero. The status register is read at word address 0.
- R3: A source counts as pending only when its status bit and its enable bit are both set, and the pending set reads at address 2. `cpu_irq` is the registered OR of the pending set, so it rises two clock edges after an enabled request input rises.
- R4: `irq_idx` is registered and names the lowest-numbered pending bit. The order is device 0, then device 1, then device 2, then the core, which reports 4.
- R5: If `cpu_irq` was high and the pending set is now empty, `spurious` is high for the next cycle together with `irq_idx` equal to the none code, and it drops again after that cycle.
- R6: A write to address 1 loads the enable register. Enable bit 3 and all bits above 4 ignore the write and read back as zero, and writing zero clears every enable bit.
- R7: A write to address 2 sets the enable bits that are 1 in the data, and a write to address 3 clears them. Enable bits whose data bit is 0 keep their value, and so do the hole bits.
- R8: A write of zero to address 0 clears the whole status register for one cycle, and the status then follows the inputs again. A write of any nonzero value to address 0 has no effect.
- R9: Status bits are level-followed, so a status bit drops one edge after its request input is released.
- R10: `reg_rdata` is registered and shows the register selected by `reg_addr` one clock edge later. Address 3 reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dev_irq | input | DEV_COUNT (3) | Level request from each device slot |
| core_irq | input | 1 | Level request from the host controller core |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Word address: 0 status, 1 enable, 2 set/pending, 3 clear |
| reg_wdata | input | DATA_W (32) | Write data |
| reg_rdata | output | DATA_W (32) | Registered read data |
| cpu_irq | output | 1 | Combined interrupt to the CPU |
| irq_idx | output | IDX_W (3) | Bit position of the winning source, all ones when none |
| spurious | output | 1 | One-cycle flag: line was high but nothing is pending |

## Verification
The bench builds the block with its defaults: three devices, the core at bit 4 and a 32-bit data word. These values leave bit 3 as a hole between the devices and the core, so the hole can be probed through both the status and the enable registers. Bit 4 holds the lowest priority, so the full priority chain runs down to the core's index of 4. Each source is peeled off in turn to walk the chain. The spurious pulse is provoked twice: once by releasing a request and once by clearing the status through the register port.

// File: rtl/pci_irq_pkg.sv
package pci_irq_pkg;

  localparam int REG_ADDR_W = 2;

  typedef enum logic [REG_ADDR_W-1:0] {
    RA_STATUS  = 2'd0,
    RA_ENABLE  = 2'd1,
    RA_SET_PND = 2'd2,
    RA_CLEAR   = 2'd3
  } reg_addr_e;

  // Mask of implemented source bits: devices at the bottom, core on top.
  function automatic logic [31:0] src_mask(input int dev_count, input int core_pos);
    logic [31:0] m;
    m = '0;
    for (int i = 0; i < 32; i++) begin
      if (i < dev_count || i == core_pos) m[i] = 1'b1;
    end
    return m;
  endfunction

endpackage

// File: rtl/irq_status_track.sv
module irq_status_track #(
  parameter int SRC_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SRC_W-1:0] raw,
  input  logic             clr,
  output logic [SRC_W-1:0] status
);

  always_ff @(posedge clk) begin
    if (rst || clr) status <= '0;
    else            status <= raw;
  end

endmodule

// File: rtl/irq_enable_file.sv
module irq_enable_file #(
  parameter int               SRC_W = 5,
  parameter logic [SRC_W-1:0] VALID = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_load,
  input  logic             wr_set,
  input  logic             wr_clr,
  input  logic [SRC_W-1:0] wbits,
  output logic [SRC_W-1:0] enable
);

  logic [SRC_W-1:0] nxt;

  always_comb begin
    nxt = enable;
    if (wr_load)     nxt = wbits;
    else if (wr_set) nxt = enable | wbits;
    else if (wr_clr) nxt = enable & ~wbits;
    nxt = nxt & VALID;
  end

  always_ff @(posedge clk) begin
    if (rst) enable <= '0;
    else     enable <= nxt;
  end

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int SRC_W = 5,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SRC_W-1:0] pending,
  output logic             cpu_irq,
  output logic [IDX_W-1:0] irq_idx,
  output logic             spurious
);

  localparam logic [IDX_W-1:0] NONE = '1;

  logic [IDX_W-1:0] pick;
  logic             any;

  // Scan from the top so that the lowest set bit is the last one assigned.
  always_comb begin
    pick = NONE;
    for (int i = SRC_W - 1; i >= 0; i--) begin
      if (pending[i]) pick = IDX_W'(i);
    end
    any = |pending;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_irq  <= 1'b0;
      irq_idx  <= NONE;
      spurious <= 1'b0;
    end else begin
      cpu_irq  <= any;
      irq_idx  <= pick;
      spurious <= cpu_irq && !any;
    end
  end

endmodule

// File: rtl/pci_irq_combiner.sv
module pci_irq_combiner #(
  parameter int DEV_COUNT = 3,
  parameter int CORE_POS  = 4,
  parameter int DATA_W    = 32,
  parameter int SRC_W     = CORE_POS + 1,
  parameter int IDX_W     = $clog2(SRC_W + 1)
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic [DEV_COUNT-1:0]               dev_irq,
  input  logic                               core_irq,
  input  logic                               reg_we,
  input  logic [pci_irq_pkg::REG_ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0]                  reg_wdata,
  output logic [DATA_W-1:0]                  reg_rdata,
  output logic                               cpu_irq,
  output logic [IDX_W-1:0]                   irq_idx,
  output logic                               spurious
);
  import pci_irq_pkg::*;

  localparam logic [31:0]      MASK32 = src_mask(DEV_COUNT, CORE_POS);
  localparam logic [SRC_W-1:0] VALID  = MASK32[SRC_W-1:0];
  localparam int               PAD_W  = DATA_W - SRC_W;

  logic [SRC_W-1:0] raw;
  logic [SRC_W-1:0] status;
  logic [SRC_W-1:0] enable;
  logic [SRC_W-1:0] pending;
  reg_addr_e        ra;
  logic             st_clr, en_load, en_set, en_clr;

  // Place every source at its bit position; holes stay tied low.
  for (genvar g = 0; g < SRC_W; g++) begin : g_map
    if (g < DEV_COUNT) begin : g_dev
      assign raw[g] = dev_irq[g];
    end else if (g == CORE_POS) begin : g_core
      assign raw[g] = core_irq;
    end else begin : g_hole
      assign raw[g] = 1'b0;
    end
  end

  assign ra      = reg_addr_e'(reg_addr);
  assign st_clr  = reg_we && ra == RA_STATUS && reg_wdata == '0;
  assign en_load = reg_we && ra == RA_ENABLE;
  assign en_set  = reg_we && ra == RA_SET_PND;
  assign en_clr  = reg_we && ra == RA_CLEAR;

  irq_status_track #(.SRC_W(SRC_W)) u_status (
    .clk    (clk),
    .rst    (rst),
    .raw    (raw),
    .clr    (st_clr),
    .status (status)
  );

  irq_enable_file #(.SRC_W(SRC_W), .VALID(VALID)) u_enable (
    .clk     (clk),
    .rst     (rst),
    .wr_load (en_load),
    .wr_set  (en_set),
    .wr_clr  (en_clr),
    .wbits   (reg_wdata[SRC_W-1:0]),
    .enable  (enable)
  );

  assign pending = status & enable;

  irq_prio_pick #(.SRC_W(SRC_W), .IDX_W(IDX_W)) u_pick (
    .clk      (clk),
    .rst      (rst),
    .pending  (pending),
    .cpu_irq  (cpu_irq),
    .irq_idx  (irq_idx),
    .spurious (spurious)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      unique case (ra)
        RA_STATUS:  reg_rdata <= {{PAD_W{1'b0}}, status};
        RA_ENABLE:  reg_rdata <= {{PAD_W{1'b0}}, enable};
        RA_SET_PND: reg_rdata <= {{PAD_W{1'b0}}, pending};
        default:    reg_rdata <= '0;
      endcase
    end
  end

endmodule

// File: rtl/pci_irq_combiner_chk.sv
module pci_irq_combiner_chk #(
  parameter int DEV_COUNT = 3,
  parameter int CORE_POS  = 4,
  parameter int DATA_W    = 32,
  parameter int SRC_W     = 5,
  parameter int IDX_W     = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_we,
  input logic [1:0]        reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [DATA_W-1:0] reg_rdata,
  input logic [SRC_W-1:0]  status,
  input logic [SRC_W-1:0]  enable,
  input logic              cpu_irq,
  input logic [IDX_W-1:0]  irq_idx,
  input logic              spurious
);

  localparam logic [31:0]      M32  = pci_irq_pkg::src_mask(DEV_COUNT, CORE_POS);
  localparam logic [DATA_W-1:0] HOLE = ~DATA_W'(M32[SRC_W-1:0]);
  localparam logic [IDX_W-1:0] NONE = '1;

  logic [SRC_W-1:0] pnd;
  assign pnd = status & enable;

  // R1
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!cpu_irq && !spurious && enable == '0 && status == '0 && irq_idx == NONE));

  // R3
  a_r3_line_rises: assert property (@(posedge clk) disable iff (rst)
    (|pnd) |=> cpu_irq);
  a_r3_line_falls: assert property (@(posedge clk) disable iff (rst)
    !(|pnd) |=> !cpu_irq);

  // R4
  a_r4_dev0_wins: assert property (@(posedge clk) disable iff (rst)
    pnd[0] |=> irq_idx == '0);
  a_r4_idx_valid: assert property (@(posedge clk) disable iff (rst)
    cpu_irq |-> irq_idx != NONE);

  // R5
  a_r5_spurious_shape: assert property (@(posedge clk) disable iff (rst)
    spurious |-> (!cpu_irq && irq_idx == NONE));

  // R6
  a_r6_holes_read_zero: assert property (@(posedge clk) disable iff (rst)
    (reg_addr == 2'd1) |=> (reg_rdata & HOLE) == '0);

  // R7
  a_r7_clear_bits: assert property (@(posedge clk) disable iff (rst)
    (reg_we && reg_addr == 2'd3) |=> (enable & $past(reg_wdata[SRC_W-1:0])) == '0);

  // R8
  a_r8_status_wipe: assert property (@(posedge clk) disable iff (rst)
    (reg_we && reg_addr == 2'd0 && reg_wdata == '0) |=> status == '0);

endmodule

bind pci_irq_combiner pci_irq_combiner_chk #(
  .DEV_COUNT (DEV_COUNT),
  .CORE_POS  (CORE_POS),
  .DATA_W    (DATA_W),
  .SRC_W     (SRC_W),
  .IDX_W     (IDX_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .reg_we    (reg_we),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .status    (status),
  .enable    (enable),
  .cpu_irq   (cpu_irq),
  .irq_idx   (irq_idx),
  .spurious  (spurious)
);

// File: tb/tb_pci_irq_combiner.sv
`timescale 1ns/1ps
module tb_pci_irq_combiner;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  dev_irq = '0;
  logic        core_irq = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        cpu_irq;
  logic [2:0]  irq_idx;
  logic        spurious;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pci_irq_combiner dut (
    .clk (clk), .rst (rst), .dev_irq (dev_irq), .core_irq (core_irq),
    .reg_we (reg_we), .reg_addr (reg_addr), .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata), .cpu_irq (cpu_irq), .irq_idx (irq_idx),
    .spurious (spurious)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    tick(1);
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    tick(1);
    d = reg_rdata;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    check("R1 cpu_irq", 32'(cpu_irq), 0);
    check("R1 spurious", 32'(spurious), 0);
    check("R1 idx none", 32'(irq_idx), 7);
    rd(2'd1, v); check("R1 enable", v, 0);
    rd(2'd0, v); check("R1 status", v, 0);
  endtask

  task automatic t_map;
    logic [31:0] v;
    dev_irq = 3'b101; core_irq = 1'b1; tick(1);
    rd(2'd0, v); check("R2 status map", v, 32'h15);
    check("R3 masked line low", 32'(cpu_irq), 0);
    dev_irq = 3'b010; core_irq = 1'b0; tick(1);
    rd(2'd0, v); check("R2 dev1 only", v, 32'h02);
    rd(2'd3, v); check("R10 addr3 zero", v, 0);
    dev_irq = 3'b000; tick(1);
    rd(2'd0, v); check("R9 released", v, 0);
  endtask

  task automatic t_enable;
    logic [31:0] v;
    wr(2'd1, 32'hFFFF_FFFF);
    rd(2'd1, v); check("R6 holes ignored", v, 32'h17);
    wr(2'd1, 32'h0);
    rd(2'd1, v); check("R6 zero clears", v, 0);
    wr(2'd2, 32'h01); rd(2'd1, v); check("R7 set bit0", v, 32'h01);
    wr(2'd2, 32'h18); rd(2'd1, v); check("R7 set core, hole ignored", v, 32'h11);
    wr(2'd3, 32'h01); rd(2'd1, v); check("R7 clear bit0", v, 32'h10);
    wr(2'd3, 32'h08); rd(2'd1, v); check("R7 clear hole no effect", v, 32'h10);
  endtask

  task automatic t_masked;
    logic [31:0] v;
    wr(2'd1, 32'h10);
    dev_irq = 3'b111; core_irq = 1'b0; tick(2);
    check("R3 disabled sources no line", 32'(cpu_irq), 0);
    check("R3 disabled sources idx", 32'(irq_idx), 7);
    rd(2'd2, v); check("R3 pending empty", v, 0);
    dev_irq = '0; tick(2);
  endtask

  task automatic t_priority;
    logic [31:0] v;
    wr(2'd1, 32'h17);
    dev_irq = 3'b111; core_irq = 1'b1; tick(1);
    check("R3 not yet after one edge", 32'(cpu_irq), 0);
    tick(1);
    check("R3 line high", 32'(cpu_irq), 1);
    check("R4 dev0 first", 32'(irq_idx), 0);
    dev_irq = 3'b110; tick(2); check("R4 dev1 next", 32'(irq_idx), 1);
    dev_irq = 3'b100; tick(2); check("R4 dev2 next", 32'(irq_idx), 2);
    dev_irq = 3'b000; tick(2); check("R4 core last", 32'(irq_idx), 4);
    check("R4 line still high", 32'(cpu_irq), 1);
    rd(2'd2, v); check("R3 pending core", v, 32'h10);
    core_irq = 1'b0; tick(3);
  endtask

  task automatic t_spurious;
    wr(2'd1, 32'h17);
    dev_irq = 3'b001; tick(2);
    check("R5 line up", 32'(cpu_irq), 1);
    dev_irq = 3'b000; tick(1);
    check("R9 line lags release", 32'(cpu_irq), 1);
    check("R5 no flag yet", 32'(spurious), 0);
    tick(1);
    check("R5 flag", 32'(spurious), 1);
    check("R5 idx none", 32'(irq_idx), 7);
    check("R5 line down", 32'(cpu_irq), 0);
    tick(1);
    check("R5 flag one cycle", 32'(spurious), 0);
  endtask

  task automatic t_status_write;
    logic [31:0] v;
    wr(2'd1, 32'h02);
    dev_irq = 3'b010; tick(2);
    check("R8 line before wipe", 32'(cpu_irq), 1);
    wr(2'd0, 32'h0);
    tick(1);
    check("R8 wipe drops line", 32'(cpu_irq), 0);
    check("R8 wipe spurious", 32'(spurious), 1);
    tick(1);
    check("R8 status resampled", 32'(cpu_irq), 1);
    dev_irq = 3'b000; tick(3);
    wr(2'd0, 32'h17);
    rd(2'd0, v); check("R8 nonzero write ignored", v, 0);
    dev_irq = 3'b001; tick(1);
    wr(2'd0, 32'h01);
    rd(2'd0, v); check("R8 nonzero write keeps status", v, 32'h01);
    dev_irq = 3'b000; tick(2);
  endtask

  task automatic t_reset_again;
    wr(2'd1, 32'h17);
    dev_irq = 3'b100; tick(2);
    rst = 1'b1; tick(1); rst = 1'b0;
    check("R1 line cleared by reset", 32'(cpu_irq), 0);
    check("R1 idx cleared by reset", 32'(irq_idx), 7);
    dev_irq = '0; tick(1);
  endtask

  initial begin
    @(negedge clk);
    tick(2);
    rst = 1'b0;
    t_reset();
    t_map();
    t_enable();
    t_masked();
    t_priority();
    t_spurious();
    t_status_write();
    t_reset_again();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule